// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three independent 16-bit down-counters behind a small byte-wide write bus. Address 3 is a shared control register. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. An internal prescaler divides the system clock into a count-enable tick; every counter that is running decrements once per tick. When a count expires, its channel sends a single-cycle pulse on its bit of `irq_o`. An interrupt controller is expected to feed channel 0, 1 and 2 into its request lines 1, 2 and 3.

Software first writes a control byte that picks a channel and sets how that channel takes its count. It then writes the count bytes to the channel's data port. Two counting behaviours are supported. One-shot mode fires once and halts. Periodic mode fires and reloads every time the count expires. The last control byte can be read back at all times. A request for decimal counting is stored and raised as a sticky status flag, but the counters still count in binary.

Top module: `tri_interval_timer`

## Requirements
- R1: A write to address 3 is a control byte with four fields. Bits 7:6 select the channel (0..2; the value 3 selects none). Bits 5:4 set the load order. Bits 3:1 set the counting mode. Bit 0 requests decimal counting. The selected channel stops, and its byte pointer and held low byte are cleared. The other channels are not affected.
- R2: With load order 3, the first data write stores the low byte. The second data write supplies the high byte and starts the count.
- R3: With load order 2, one data write loads the count {byte, 0x00} and starts it at once.
- R4: A tick occurs once every TICK_DIV clocks. A count N that is loaded at edge L pulses at the first tick edge strictly after L, plus (N-1)*TICK_DIV clocks. A tick on the same edge as the load is not counted.
- R5: In mode 0 (one-shot) a channel pulses exactly once per load and then stays halted.
- R6: In mode 3 (periodic) a channel pulses every N*TICK_DIV clocks until it is reconfigured.
- R7: A loaded count of 0 behaves as 65536 ticks.
- R8: Each expiry gives a pulse of exactly one clock on `irq_o[i]` for channel i. Channels that expire on the same tick pulse in the same cycle.
- R9: `ctrl_rdata_o` shows the last control byte written, including bytes that select no channel.
- R10: `bcd_unsupported_o` is set by any control byte with bit 0 set and stays set until reset.
- R11: Data writes start no count when the counting mode is not 0 or 3, or when the load order is 0 or 1.
- R12: If a control byte reaches a channel on the same edge as its terminal tick, no pulse is sent.
- R13: After reset all pulses are low, the read-back is 0x00, the decimal flag is low and every channel is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | 0..2 channel data, 3 control |
| wdata_i | input | 8 | Write data |
| ctrl_rdata_o | output | 8 | Last control byte written |
| bcd_unsupported_o | output | 1 | Sticky flag for a decimal-count request |
| irq_o | output | NUM_CH | Per-channel expiry pulses |

## Verification
Two channels can expire on the same tick. A bus write can also land on a channel's tick edge. Channel 0 runs periodically with a count of 1 and serves as a phase reference. From its pulse, channel 1 is loaded with count 4 one edge before a tick, and channel 2 with count 3 exactly on the tick edge. Both are then expected to pulse in the same cycle. In a separate step a control byte is timed to land on channel 0's terminal edge, and the bench checks that no pulse appears and that the channel stays halted.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    LD_LATCH = 2'd0,
    LD_LOW   = 2'd1,
    LD_HIGH  = 2'd2,
    LD_LOHI  = 2'd3
  } load_mode_e;

  localparam logic [2:0] MODE_ONESHOT = 3'd0;
  localparam logic [2:0] MODE_SQUARE  = 3'd3;

  typedef struct packed {
    logic [1:0] sel;
    load_mode_e ld;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;
endpackage

// File: rtl/tri_timer_tick_gen.sv
module tri_timer_tick_gen #(
  parameter int DIV = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic         tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  generate
    if (DIV > 1) begin : g_gap
      // R4
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/tri_timer_ctrl_port.sv
module tri_timer_ctrl_port
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [7:0]        wdata_i,
  output logic [NUM_CH-1:0] cfg_wr_o,
  output load_mode_e        cfg_ld_o,
  output logic [2:0]        cfg_mode_o,
  output logic [7:0]        ctrl_q_o,
  output logic              bcd_o
);
  ctrl_word_t word;
  logic [7:0] ctrl_q;
  logic       bcd_q;

  assign word = ctrl_word_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      bcd_q  <= 1'b0;
    end else if (ctrl_wr_i) begin
      ctrl_q <= wdata_i;
      if (word.bcd) bcd_q <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign cfg_wr_o[i] = ctrl_wr_i && (word.sel == 2'(i));
    end
  endgenerate

  assign cfg_ld_o   = word.ld;
  assign cfg_mode_o = word.mode;
  assign ctrl_q_o   = ctrl_q;
  assign bcd_o      = bcd_q;

  // R9
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (ctrl_q == $past(wdata_i)));
  // R10
  bcd_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_q |=> bcd_q);
  // R1
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_wr_o));
endmodule

// File: rtl/tri_timer_channel.sv
module tri_timer_channel
  import tri_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cfg_wr_i,
  input  load_mode_e cfg_ld_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       data_wr_i,
  input  logic [7:0] data_i,
  output logic       irq_o
);
  load_mode_e       ld_q;
  logic [2:0]       mode_q;
  logic             ptr_q;
  logic [7:0]       lo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic             run_q;
  logic             irq_q;

  logic             load_now;
  logic             mode_ok;
  logic [CNT_W-1:0] load_val;

  assign mode_ok  = (mode_q == MODE_ONESHOT) || (mode_q == MODE_SQUARE);
  assign load_now = data_wr_i && ((ld_q == LD_HIGH) || (ld_q == LD_LOHI && ptr_q));
  assign load_val = (ld_q == LD_LOHI) ? {data_i, lo_q} : {data_i, 8'h00};

  // byte pointer and held low byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= 1'b0;
      lo_q  <= '0;
    end else if (cfg_wr_i) begin
      ptr_q <= 1'b0;
      lo_q  <= '0;
    end else if (data_wr_i && ld_q == LD_LOHI) begin
      if (!ptr_q) begin
        ptr_q <= 1'b1;
        lo_q  <= data_i;
      end else begin
        ptr_q <= 1'b0;
        lo_q  <= '0;
      end
    end
  end

  // config, load and count; config beats load beats tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q     <= LD_LATCH;
      mode_q   <= MODE_ONESHOT;
      cnt_q    <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_wr_i) begin
        ld_q   <= cfg_ld_i;
        mode_q <= cfg_mode_i;
        run_q  <= 1'b0;
      end else if (load_now) begin
        cnt_q    <= load_val;
        reload_q <= load_val;
        run_q    <= mode_ok;
      end else if (run_q && tick_i) begin
        if (cnt_q == CNT_W'(1)) begin
          irq_q <= 1'b1;
          if (mode_q == MODE_SQUARE) begin
            cnt_q <= reload_q;
          end else begin
            cnt_q <= '0;
            run_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign irq_o = irq_q;

  // R4
  irq_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(tick_i));
  // R5
  oneshot_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && mode_q == MODE_ONESHOT) |-> !run_q);
  // R6
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && mode_q == MODE_SQUARE) |-> (run_q && cnt_q == reload_q));
  // R1
  cfg_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> (!run_q && !ptr_q));
  // R11
  run_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> mode_ok);
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int TICK_DIV = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        ctrl_rdata_o,
  output logic              bcd_unsupported_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic              tick;
  logic              ctrl_wr;
  logic [NUM_CH-1:0] cfg_wr;
  load_mode_e        cfg_ld;
  logic [2:0]        cfg_mode;

  assign ctrl_wr = wr_i && (addr_i == CTRL_ADDR);

  tri_timer_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  tri_timer_ctrl_port #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (ctrl_wr),
    .wdata_i    (wdata_i),
    .cfg_wr_o   (cfg_wr),
    .cfg_ld_o   (cfg_ld),
    .cfg_mode_o (cfg_mode),
    .ctrl_q_o   (ctrl_rdata_o),
    .bcd_o      (bcd_unsupported_o)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic data_wr;
      assign data_wr = wr_i && (addr_i == 2'(i));
      tri_timer_channel i_chan (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .cfg_wr_i   (cfg_wr[i]),
        .cfg_ld_i   (cfg_ld),
        .cfg_mode_i (cfg_mode),
        .data_wr_i  (data_wr),
        .data_i     (wdata_i),
        .irq_o      (irq_o[i])
      );
    end
  endgenerate
endmodule

// File: tb/test_tri_interval_timer.sv
module test_tri_interval_timer;
  localparam int DIV = 2;
  localparam int NCH = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_i = 1'b0;
  logic [1:0]     addr_i = '0;
  logic [7:0]     wdata_i = '0;
  logic [7:0]     ctrl_rdata_o;
  logic           bcd_unsupported_o;
  logic [NCH-1:0] irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int pcount [NCH];
  int last   [NCH];
  int prevp  [NCH];
  bit hi_q   [NCH];
  int dbl = 0;
  int both_seen = 0;

  tri_interval_timer #(.NUM_CH(NCH), .TICK_DIV(DIV)) i_tri_interval_timer (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .wr_i              (wr_i),
    .addr_i            (addr_i),
    .wdata_i           (wdata_i),
    .ctrl_rdata_o      (ctrl_rdata_o),
    .bcd_unsupported_o (bcd_unsupported_o),
    .irq_o             (irq_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  initial begin
    for (int i = 0; i < NCH; i++) begin
      pcount[i] = 0; last[i] = -1; prevp[i] = -1; hi_q[i] = 0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        if (irq_o[i]) begin
          if (hi_q[i]) dbl++;
          pcount[i]++;
          prevp[i] = last[i];
          last[i] = cyc;
        end
        hi_q[i] = irq_o[i];
      end
      if (irq_o[1] && irq_o[2]) both_seen++;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    step(1);
    wr_i = 1'b0;
  endtask

  task automatic sync(output int t0);
    do step(1); while (!irq_o[0]);
    t0 = cyc;
  endtask

  function automatic int exp_edge(input int t0, input int l, input int n);
    return t0 + DIV * ((l - t0) / DIV + 1) + (n - 1) * DIV;
  endfunction

  initial begin
    int t0, l, b, b2, e1, e2, tb;
    step(3);
    // R13 reset state
    check(irq_o == 0, "R13", irq_o, 0);
    check(ctrl_rdata_o == 8'h00, "R13", ctrl_rdata_o, 0);
    check(bcd_unsupported_o == 1'b0, "R13", bcd_unsupported_o, 0);
    rst_ni = 1'b1;
    step(2 * DIV);
    check(pcount[0] + pcount[1] + pcount[2] == 0, "R13", pcount[0], 0);

    // reference: ch0 periodic, count 1
    wr(2'd3, 8'h36);
    check(ctrl_rdata_o == 8'h36, "R9", ctrl_rdata_o, 8'h36);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    sync(t0);
    step(4 * DIV);
    check(last[0] - prevp[0] == DIV, "R6", last[0] - prevp[0], DIV);
    check(dbl == 0, "R8", dbl, 0);

    // R5 R2 R4: one-shot sweep on ch1
    for (int n = 1; n <= 8; n++) begin
      wr(2'd3, 8'h70);
      wr(2'd1, 8'(n));
      sync(t0);
      b = pcount[1];
      wr(2'd1, 8'h00);
      l = cyc;
      e1 = exp_edge(t0, l, n);
      step((n + 4) * DIV);
      check(pcount[1] - b == 1, "R5", pcount[1] - b, 1);
      check(last[1] == e1, "R4", last[1], e1);
    end

    // R6: periodic sweep on ch2
    for (int n = 1; n <= 6; n++) begin
      wr(2'd3, 8'hB6);
      wr(2'd2, 8'(n));
      wr(2'd2, 8'h00);
      do step(1); while (!irq_o[2]);
      b = pcount[2];
      tb = cyc;
      step(3 * n * DIV);
      check(pcount[2] - b == 3, "R6", pcount[2] - b, 3);
      check(last[2] == tb + 3 * n * DIV, "R6", last[2], tb + 3 * n * DIV);
    end
    // R1: control write halts the channel
    wr(2'd3, 8'hB6);
    b = pcount[2];
    step(20 * DIV);
    check(pcount[2] == b, "R1", pcount[2] - b, 0);

    // R8 R12: simultaneous expiry, load on a tick edge
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h04);
    wr(2'd3, 8'hB0);
    wr(2'd2, 8'h03);
    both_seen = 0;
    sync(t0);
    b = pcount[1]; b2 = pcount[2];
    wr(2'd1, 8'h00);
    e1 = exp_edge(t0, cyc, 4);
    wr(2'd2, 8'h00);
    e2 = exp_edge(t0, cyc, 3);
    step(8 * DIV);
    check(last[1] == e1 && pcount[1] - b == 1, "R8", last[1], e1);
    check(last[2] == e2 && pcount[2] - b2 == 1, "R12", last[2], e2);
    check((both_seen != 0) == (e1 == e2), "R8", both_seen, (e1 == e2));

    // R12: control write on the terminal edge suppresses the pulse
    sync(t0);
    step(DIV - 1);
    b = pcount[0];
    wr(2'd3, 8'h36);
    step(4 * DIV);
    check(pcount[0] == b, "R12", pcount[0] - b, 0);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);

    // R1 R2: rewriting the control byte drops a held low byte
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h09);
    wr(2'd3, 8'h70);
    wr(2'd1, 8'h02);
    sync(t0);
    b = pcount[1];
    wr(2'd1, 8'h00);
    e1 = exp_edge(t0, cyc, 2);
    step(6 * DIV);
    check(pcount[1] - b == 1 && last[1] == e1, "R1", last[1], e1);

    // R3: high byte only
    wr(2'd3, 8'h60);
    sync(t0);
    b = pcount[1];
    wr(2'd1, 8'h01);
    e1 = exp_edge(t0, cyc, 256);
    step(260 * DIV);
    check(pcount[1] - b == 1, "R3", pcount[1] - b, 1);
    check(last[1] == e1, "R3", last[1], e1);

    // R11: unsupported mode and load orders start nothing
    b = pcount[1];
    wr(2'd3, 8'h72);
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h00);
    step(10 * DIV);
    check(pcount[1] == b, "R11", pcount[1] - b, 0);
    wr(2'd3, 8'h40);
    check(ctrl_rdata_o == 8'h40, "R9", ctrl_rdata_o, 8'h40);
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h50);
    wr(2'd1, 8'h03);
    step(10 * DIV);
    check(pcount[1] == b, "R11", pcount[1] - b, 0);

    // R1 R9: channel field 3 selects nothing
    wr(2'd3, 8'h76);
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h00);
    do step(1); while (!irq_o[1]);
    wr(2'd3, 8'hF6);
    check(ctrl_rdata_o == 8'hF6, "R9", ctrl_rdata_o, 8'hF6);
    do step(1); while (!irq_o[1]);
    b = pcount[1];
    step(4 * 2 * DIV);
    check(pcount[1] - b == 4, "R1", pcount[1] - b, 4);
    wr(2'd3, 8'h70);

    // R10: decimal request flag
    check(bcd_unsupported_o == 1'b0, "R10", bcd_unsupported_o, 0);
    wr(2'd3, 8'h71);
    check(bcd_unsupported_o == 1'b1, "R10", bcd_unsupported_o, 1);
    check(ctrl_rdata_o == 8'h71, "R9", ctrl_rdata_o, 8'h71);
    wr(2'd3, 8'h70);
    check(bcd_unsupported_o == 1'b1, "R10", bcd_unsupported_o, 1);

    // R7: zero count means 65536
    wr(2'd3, 8'hA0);
    sync(t0);
    b = pcount[2];
    wr(2'd2, 8'h00);
    e2 = exp_edge(t0, cyc, 65536);
    step(65540 * DIV);
    check(pcount[2] - b == 1, "R7", pcount[2] - b, 1);
    check(last[2] == e2, "R7", last[2], e2);

    check(dbl == 0, "R8", dbl, 0);
    summary();
  end
endmodule